// File: doc/BRIEF.md
# Capability Field Query Unit

This unit executes the family of instructions that copy a single field of a 257-bit capability register into a 64-bit general-purpose result. Each cycle it may take one 32-bit instruction word together with the program-counter capability's five access bits. It decodes which field is wanted and presents the source register index to the capability register file. It reads the returned capability in the same cycle.

One cycle after an accepted word, the unit produces exactly one outcome. The first is a GPR write, with its index and data. The second is an access exception request, which carries the offending register number and a cause code. The third is a reserved-instruction flag for words that match no query encoding. The top five capability registers are privileged: each one can be read only when its matching access bit of the program-counter capability is set. When that bit is clear, the register file read is suppressed and the exception path is taken.

Top module: `cap_query_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `gpr_we`, `exc_req` and `rsvd_instr` are low.
- R2: Each outcome pulse appears exactly one clock after a cycle with `in_valid` high. A cycle without `in_valid` produces no outcome in the next cycle.
- R3: A word with bits 31:26 = 6'b010010, bits 25:21 = 0 and bits 10:3 = 0 selects its field by bits 2:0. The codes are: 000 returns capability bits 223:193 zero-extended; 001 returns the object type (bits 247:224) zero-extended; 010 returns the base (bits 127:64); 011 returns the length (bits 63:0); 101 returns the tag (bit 256) zero-extended; 110 returns the sealed flag (bit 192) zero-extended.
- R4: A word with bits 31:26 = 6'b010010, bits 25:21 = 5'b01101, bits 10:3 = 0 and bits 2:0 = 010 returns the cursor (bits 191:128).
- R5: Some words give `rsvd_instr` one cycle later, with neither a GPR write nor an exception. These are: any other opcode; nonzero bits 10:3; low code 100 or 111 with bits 25:21 = 0; any bits 25:21 value other than 0 and 01101; and 01101 with a low code other than 010.
- R6: Source registers 27, 28, 29, 30 and 31 are accessible only when `pcc_access` bit 0, 1, 2, 3 or 4 respectively is set.
- R7: A well-formed query on an inaccessible register raises `exc_req` with no GPR write. `exc_regnum` is the source index zero-extended to 8 bits. `exc_code` is 8'h1d for register 27, 8'h1e for 28, 8'h1c for 29, 8'h1b for 30 and 8'h1a for 31.
- R8: Source registers 0 to 26 are accessible whatever the value of `pcc_access`.
- R9: On a GPR write, `gpr_waddr` equals bits 20:16 of the word.
- R10: At most one of `gpr_we`, `exc_req` and `rsvd_instr` is high in any cycle.
- R11: `cap_rd_idx` always shows bits 15:11 of the word. `cap_rd_en` is high in the same cycle only for a valid, well-formed word whose source register is accessible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word strobe |
| instr | input | 32 | Instruction word |
| pcc_access | input | 5 | Access bits of the program-counter capability for registers 27..31 |
| cap_rd_en | output | 1 | Capability register file read enable |
| cap_rd_idx | output | 5 | Capability register file read index |
| cap_rd_data | input | 257 | Capability read data |
| gpr_we | output | 1 | GPR write enable |
| gpr_waddr | output | 5 | GPR write index |
| gpr_wdata | output | 64 | GPR write data |
| exc_req | output | 1 | Access exception request |
| exc_regnum | output | 8 | Register number carried with the exception |
| exc_code | output | 8 | Exception cause code |
| rsvd_instr | output | 1 | Reserved-instruction flag |

## Verification
The bench targets the offset encoding, whose bits 25:21 break the regular pattern. A decoder that ignored those bits would flag the word as reserved or return the base instead of the cursor. It sweeps each privileged register with its own access bit both set and clear. A wrong bit-to-register mapping would then show up as a spurious exception or a leaked read with the wrong cause code. Low codes 100 and 111, and nonzero bits 10:3, are driven so that loose decoding would appear as a GPR write. Registers below 27 are issued with all access bits clear to catch over-eager gating.

// File: rtl/capq_pkg.sv
package capq_pkg;

    localparam int unsigned CAP_W    = 257;
    localparam logic [5:0]  OP_CAP2  = 6'b010010;
    localparam logic [4:0]  FMT_STD  = 5'b00000;
    localparam logic [4:0]  FMT_CUR  = 5'b01101;

    typedef struct packed {
        logic        tag;
        logic [7:0]  pad;
        logic [23:0] otype;
        logic [30:0] perms;
        logic        sealed;
        logic [63:0] cursor;
        logic [63:0] base;
        logic [63:0] length;
    } cap_t;

    typedef enum logic [2:0] {
        Q_PERMS  = 3'd0,
        Q_OTYPE  = 3'd1,
        Q_BASE   = 3'd2,
        Q_LENGTH = 3'd3,
        Q_CURSOR = 3'd4,
        Q_TAG    = 3'd5,
        Q_SEALED = 3'd6
    } query_e;

    typedef struct packed {
        logic       ok;
        query_e     q;
        logic [4:0] rd;
        logic [4:0] cb;
    } dec_t;

    // Cause code for a privileged register, index 0 = lowest protected register
    function automatic logic [7:0] prot_code(input logic [2:0] slot);
        case (slot)
            3'd0:    prot_code = 8'h1d;
            3'd1:    prot_code = 8'h1e;
            3'd2:    prot_code = 8'h1c;
            3'd3:    prot_code = 8'h1b;
            default: prot_code = 8'h1a;
        endcase
    endfunction

endpackage

// File: rtl/capq_decoder.sv
module capq_decoder
    import capq_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);
    logic head_ok;
    logic fmt_std;
    logic fmt_cur;

    assign head_ok = (word[31:26] == OP_CAP2) && (word[10:3] == 8'd0);
    assign fmt_std = (word[25:21] == FMT_STD);
    assign fmt_cur = (word[25:21] == FMT_CUR);

    always_comb begin
        dec.ok = 1'b0;
        dec.q  = Q_PERMS;
        dec.rd = word[20:16];
        dec.cb = word[15:11];
        if (head_ok && fmt_std) begin
            dec.ok = 1'b1;
            case (word[2:0])
                3'b000:  dec.q = Q_PERMS;
                3'b001:  dec.q = Q_OTYPE;
                3'b010:  dec.q = Q_BASE;
                3'b011:  dec.q = Q_LENGTH;
                3'b101:  dec.q = Q_TAG;
                3'b110:  dec.q = Q_SEALED;
                default: dec.ok = 1'b0;
            endcase
        end else if (head_ok && fmt_cur && word[2:0] == 3'b010) begin
            dec.ok = 1'b1;
            dec.q  = Q_CURSOR;
        end
    end
endmodule

// File: rtl/capq_access.sv
module capq_access
    import capq_pkg::*;
#(
    parameter int unsigned NREG  = 32,
    parameter int unsigned NPROT = 5,
    localparam int unsigned IW   = $clog2(NREG),
    localparam int unsigned FIRST = NREG - NPROT
) (
    input  logic [IW-1:0]    idx,
    input  logic [NPROT-1:0] perm,
    output logic             allowed,
    output logic [7:0]       code
);
    logic [NPROT-1:0] hit;
    logic [NPROT-1:0] deny;

    for (genvar i = 0; i < NPROT; i++) begin : g_prot
        assign hit[i]  = (idx == IW'(FIRST + i));
        assign deny[i] = hit[i] & ~perm[i];
    end

    assign allowed = ~|deny;

    always_comb begin
        code = 8'h00;
        for (int i = 0; i < NPROT; i++) begin
            if (hit[i]) code = prot_code(3'(i));
        end
    end
endmodule

// File: rtl/capq_extract.sv
module capq_extract
    import capq_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  cap_t             cap,
    input  query_e           q,
    output logic [XLEN-1:0]  value
);
    always_comb begin
        case (q)
            Q_PERMS:  value = XLEN'(cap.perms);
            Q_OTYPE:  value = XLEN'(cap.otype);
            Q_BASE:   value = XLEN'(cap.base);
            Q_LENGTH: value = XLEN'(cap.length);
            Q_CURSOR: value = XLEN'(cap.cursor);
            Q_TAG:    value = XLEN'(cap.tag);
            Q_SEALED: value = XLEN'(cap.sealed);
            default:  value = '0;
        endcase
    end
endmodule

// File: rtl/cap_query_unit.sv
module cap_query_unit
    import capq_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned NREG  = 32,
    parameter int unsigned NPROT = 5,
    localparam int unsigned IW   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [31:0]        instr,
    input  logic [NPROT-1:0]   pcc_access,
    output logic               cap_rd_en,
    output logic [IW-1:0]      cap_rd_idx,
    input  logic [CAP_W-1:0]   cap_rd_data,
    output logic               gpr_we,
    output logic [4:0]         gpr_waddr,
    output logic [XLEN-1:0]    gpr_wdata,
    output logic               exc_req,
    output logic [7:0]         exc_regnum,
    output logic [7:0]         exc_code,
    output logic               rsvd_instr
);
    dec_t            dec;
    logic            allowed;
    logic [7:0]      code;
    logic [XLEN-1:0] value;
    logic            do_write;
    logic            do_exc;
    logic            do_rsvd;

    capq_decoder u_dec (
        .word (instr),
        .dec  (dec)
    );

    capq_access #(.NREG(NREG), .NPROT(NPROT)) u_acc (
        .idx     (IW'(dec.cb)),
        .perm    (pcc_access),
        .allowed (allowed),
        .code    (code)
    );

    capq_extract #(.XLEN(XLEN)) u_ext (
        .cap   (cap_t'(cap_rd_data)),
        .q     (dec.q),
        .value (value)
    );

    assign do_write   = in_valid & dec.ok & allowed;
    assign do_exc     = in_valid & dec.ok & ~allowed;
    assign do_rsvd    = in_valid & ~dec.ok;
    assign cap_rd_en  = do_write;
    assign cap_rd_idx = IW'(dec.cb);

    always_ff @(posedge clk) begin
        if (rst) begin
            gpr_we     <= 1'b0;
            gpr_waddr  <= '0;
            gpr_wdata  <= '0;
            exc_req    <= 1'b0;
            exc_regnum <= '0;
            exc_code   <= '0;
            rsvd_instr <= 1'b0;
        end else begin
            gpr_we     <= do_write;
            exc_req    <= do_exc;
            rsvd_instr <= do_rsvd;
            gpr_waddr  <= do_write ? dec.rd : '0;
            gpr_wdata  <= do_write ? value : '0;
            exc_regnum <= do_exc ? 8'(dec.cb) : '0;
            exc_code   <= do_exc ? code : '0;
        end
    end
endmodule

// File: rtl/capq_checker.sv
module capq_checker #(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned NPROT = 5,
    parameter int unsigned IW    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [31:0]      instr,
    input logic [NPROT-1:0] pcc_access,
    input logic             cap_rd_en,
    input logic [IW-1:0]    cap_rd_idx,
    input logic             gpr_we,
    input logic [4:0]       gpr_waddr,
    input logic [XLEN-1:0]  gpr_wdata,
    input logic             exc_req,
    input logic [7:0]       exc_regnum,
    input logic             rsvd_instr
);
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gpr_we, exc_req, rsvd_instr}));

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !(gpr_we || exc_req || rsvd_instr));

    assert_outcome_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (gpr_we || exc_req || rsvd_instr));

    assert_waddr_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cap_rd_en) |=> (gpr_we && gpr_waddr == $past(instr[20:16])));

    assert_exc_regnum_R7: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (exc_regnum >= 8'd27 && !gpr_we));

    assert_rden_valid_R11: assert property (@(posedge clk) disable iff (rst)
        cap_rd_en |-> in_valid);

    assert_rdidx_R11: assert property (@(posedge clk) disable iff (rst)
        cap_rd_idx == instr[15:11]);

    assert_low_regs_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[15:11] < 5'd27) |=> !exc_req);
endmodule

bind cap_query_unit capq_checker #(.XLEN(XLEN), .NPROT(NPROT), .IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .instr      (instr),
    .pcc_access (pcc_access),
    .cap_rd_en  (cap_rd_en),
    .cap_rd_idx (cap_rd_idx),
    .gpr_we     (gpr_we),
    .gpr_waddr  (gpr_waddr),
    .gpr_wdata  (gpr_wdata),
    .exc_req    (exc_req),
    .exc_regnum (exc_regnum),
    .rsvd_instr (rsvd_instr)
);

// File: tb/cap_query_unit_tb.sv
module cap_query_unit_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [4:0]   pcc_access = '0;
    logic         cap_rd_en;
    logic [4:0]   cap_rd_idx;
    logic [256:0] cap_rd_data = '0;
    logic         gpr_we;
    logic [4:0]   gpr_waddr;
    logic [63:0]  gpr_wdata;
    logic         exc_req;
    logic [7:0]   exc_regnum;
    logic [7:0]   exc_code;
    logic         rsvd_instr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cap_query_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .pcc_access(pcc_access), .cap_rd_en(cap_rd_en), .cap_rd_idx(cap_rd_idx),
        .cap_rd_data(cap_rd_data), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr),
        .gpr_wdata(gpr_wdata), .exc_req(exc_req), .exc_regnum(exc_regnum),
        .exc_code(exc_code), .rsvd_instr(rsvd_instr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] fmt, input logic [4:0] rd,
                                       input logic [4:0] cb, input logic [2:0] lo);
        return {6'b010010, fmt, rd, cb, 8'd0, lo};
    endfunction

    // Expected behaviour written from the requirements
    task automatic model(input logic [31:0] w, input logic [256:0] c, input logic [4:0] p,
                         output int kind, output logic [63:0] d, output logic [7:0] code,
                         output string req);
        bit well;
        bit acc;
        well = 0; d = '0; code = 8'h00; req = "R5";
        if (w[31:26] == 6'b010010 && w[10:3] == 0) begin
            if (w[25:21] == 0) begin
                well = 1; req = "R3";
                case (w[2:0])
                    3'b000: d = {33'd0, c[223:193]};
                    3'b001: d = {40'd0, c[247:224]};
                    3'b010: d = c[127:64];
                    3'b011: d = c[63:0];
                    3'b101: d = {63'd0, c[256]};
                    3'b110: d = {63'd0, c[192]};
                    default: begin well = 0; req = "R5"; end
                endcase
            end else if (w[25:21] == 5'b01101 && w[2:0] == 3'b010) begin
                well = 1; req = "R4"; d = c[191:128];
            end
        end
        acc = 1;
        case (w[15:11])
            5'd27: begin acc = p[0]; code = 8'h1d; end
            5'd28: begin acc = p[1]; code = 8'h1e; end
            5'd29: begin acc = p[2]; code = 8'h1c; end
            5'd30: begin acc = p[3]; code = 8'h1b; end
            5'd31: begin acc = p[4]; code = 8'h1a; end
            default: acc = 1;
        endcase
        if (!well) kind = 2;
        else if (!acc) begin kind = 1; req = "R7"; end
        else kind = 0;
    endtask

    // Call at a negative edge; returns at the next negative edge
    task automatic issue(input logic [31:0] w, input logic [4:0] p);
        int kind;
        logic [63:0] d;
        logic [7:0] code;
        string req;
        instr = w; pcc_access = p; in_valid = 1'b1;
        cap_rd_data = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, 1'($urandom)};
        model(w, cap_rd_data, p, kind, d, code, req);
        #1;
        check(cap_rd_en == (kind == 0), "R11", 64'(cap_rd_en), 64'(kind == 0));
        check(cap_rd_idx == w[15:11], "R11", 64'(cap_rd_idx), 64'(w[15:11]));
        @(negedge clk);
        check({gpr_we, exc_req, rsvd_instr} == {kind == 0, kind == 1, kind == 2}, req,
              64'({gpr_we, exc_req, rsvd_instr}), 64'({kind == 0, kind == 1, kind == 2}));
        if (kind == 0) begin
            check(gpr_wdata == d, req, gpr_wdata, d);
            check(gpr_waddr == w[20:16], "R9", 64'(gpr_waddr), 64'(w[20:16]));
        end else if (kind == 1) begin
            check(exc_regnum == {3'd0, w[15:11]}, "R7", 64'(exc_regnum), 64'(w[15:11]));
            check(exc_code == code, "R7", 64'(exc_code), 64'(code));
        end
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
        check(!(gpr_we || exc_req || rsvd_instr), "R2", 64'({gpr_we, exc_req, rsvd_instr}), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!(gpr_we || exc_req || rsvd_instr), "R1", 64'({gpr_we, exc_req, rsvd_instr}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!(gpr_we || exc_req || rsvd_instr), "R1", 64'({gpr_we, exc_req, rsvd_instr}), 64'd0);

        // R3: every regular field code
        for (int lo = 0; lo < 8; lo++) issue(mk(5'd0, 5'd3, 5'd7, 3'(lo)), 5'd0);
        // R4: cursor encoding, and its near misses (R5)
        issue(mk(5'b01101, 5'd9, 5'd4, 3'b010), 5'd0);
        issue(mk(5'b01101, 5'd9, 5'd4, 3'b011), 5'd0);
        issue(mk(5'b01100, 5'd9, 5'd4, 3'b010), 5'd0);
        // R5: nonzero bits 10:3 and wrong opcode
        issue(mk(5'd0, 5'd1, 5'd2, 3'b010) | 32'h0000_0040, 5'd0);
        issue(mk(5'd0, 5'd1, 5'd2, 3'b010) ^ 32'h0400_0000, 5'd0);
        // R6, R7: each privileged register with its bit clear then set
        for (int r = 27; r < 32; r++) begin
            issue(mk(5'd0, 5'd5, 5'(r), 3'b010), 5'h1f & ~(5'd1 << (r - 27)));
            issue(mk(5'd0, 5'd5, 5'(r), 3'b010), 5'd1 << (r - 27));
        end
        // R7: a reserved word on a privileged register stays reserved
        issue(mk(5'd0, 5'd5, 5'd31, 3'b111), 5'd0);
        // R8: unprivileged registers with no access bits
        for (int r = 0; r < 27; r += 13) issue(mk(5'd0, 5'd6, 5'(r), 3'b011), 5'd0);
        // R2: gap then back-to-back
        idle();
        idle();
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            int k;
            k = int'($urandom % 10);
            w = mk(5'd0, 5'($urandom), ($urandom % 2) ? 5'(27 + $urandom % 5) : 5'($urandom), 3'($urandom));
            if (k == 7) w[25:21] = 5'b01101;
            else if (k == 8) w[10:3] = 8'($urandom);
            else if (k == 9) w = $urandom;
            issue(w, 5'($urandom));
            if (k == 0) idle();
        end
        in_valid = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule